// File: doc/BRIEF.md
# DDR3 Power-Up Sequence Monitor

This block sits passively beside a DDR3 command bus and follows the bring-up that a memory controller performs after power is applied. It decodes every clock's command from the reset, clock-enable and strobe pins, tracks which bring-up step the controller has reached, and counts the clocks spent in the current step. When a command arrives before its minimum idle spacing has elapsed, when the wrong command (or the right command aimed at the wrong mode register or bank scope) arrives, or when power control drops after clock enable was raised, it raises a one-cycle error pulse tagged with the failing step.

Once the last idle window after the refresh has elapsed, the monitor reports the controller as operational and keeps watching for two things: mode-register writes, which are no longer permitted, and loss of clock enable. The first violation freezes the step number, the clock count and the error kind until a synchronous reset of the monitor, so software or a testbench can read what went wrong long after the pulse. It never drives the memory bus and ignores data transfers.

Top module: `ddr3_init_monitor`

## Requirements
- R1: Each clock the pins form a 6-bit code {~reset_n, ~cke, cs_n, ras_n, cas_n, we_n}. With cs_n high the cycle is a deselect and is treated exactly like NOOP; with cs_n low, {ras_n,cas_n,we_n} = 000 MRS, 001 REFRESH, 010 PRECHARGE, 011 ACTIVATE, 100 WRITE, 101 READ, 110 ZQ calibration, 111 NOOP.
- R2: After a synchronous reset (rst high) phase is 0, phase_count is 0, init_done is 0, err_pulse is 0 and err_kind is 0 (none).
- R3: Phase 0 lasts until a clock where reset_n and cke are both high; at that edge phase becomes 1. Each later advance moves the phase up by exactly one, through 1 to 8, in this order of accepted commands: MRS with bank 2 (leaves 1), MRS with bank 1 (leaves 2), MRS with bank 0 (leaves 3), ZQ with address bit 10 high (leaves 4), PRECHARGE with address bit 10 high (leaves 5), REFRESH (leaves 6).
- R4: In phases 1 to 6, a non-NOOP command that is not the one listed in R3 for that phase raises err_kind 2 (bad command).
- R5: In phases 1 to 6 the expected command is accepted only when phase_count is at least 148, 4, 4, 12, 513 and 4 respectively; otherwise it raises err_kind 1 (too early).
- R6: In phases 1 to 8, a clock with cke low or reset_n low raises err_kind 3 (power lost); this takes priority over every other check.
- R7: In phase 7 any non-NOOP raises err_kind 2; after 141 NOOP clocks the phase becomes 8 and init_done is 1, and it is still 0 after 140.
- R8: In phase 8 an MRS raises err_kind 2; all other commands are accepted silently.
- R9: An error gives err_pulse high for exactly one clock, with err_phase equal to the phase; phase, phase_count and err_kind then hold their values until rst, and further violations raise nothing.
- R10: phase_count is 0 on the clock after a phase is entered and rises by one per accepted clock, saturating at its maximum (4095 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst | input | 1 | Synchronous active-high reset of the monitor |
| mem_reset_n | input | 1 | Observed memory reset, active low |
| mem_cke | input | 1 | Observed clock enable |
| mem_cs_n | input | 1 | Observed chip select, active low |
| mem_ras_n | input | 1 | Observed row strobe, active low |
| mem_cas_n | input | 1 | Observed column strobe, active low |
| mem_we_n | input | 1 | Observed write enable, active low |
| mem_ba | input | BA_W | Observed bank address (mode register select for MRS) |
| mem_a10 | input | 1 | Observed address bit 10 (long calibration / all-bank scope) |
| err_pulse | output | 1 | One-clock error strobe |
| err_kind | output | 2 | Latched error kind: 0 none, 1 early, 2 bad command, 3 power lost |
| err_phase | output | 4 | Phase in which the error was raised |
| phase | output | 4 | Current bring-up phase, 0..8 |
| phase_count | output | CNT_W | Clocks accepted in the current phase |
| init_done | output | 1 | High once phase 8 (operational) is reached |

## Verification
The hardest states to reach are the late ones: a zero-margin check on the 513-clock calibration window or an illegal command inside the post-refresh idle window only exists after every earlier step has been issued legally with its exact spacing. The bench therefore builds a reusable legal bring-up routine that stops at any chosen phase, then appends one faulty command at a gap one short of, or exactly at, the minimum. Saturation of the clock count is reached by idling several thousand clocks in the operational phase before dropping clock enable, so the frozen count can be compared against the saturated value.

// File: rtl/ddr3_init_mon_pkg.sv
package ddr3_init_mon_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'd0,
        CMD_REF = 3'd1,
        CMD_PRE = 3'd2,
        CMD_ACT = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RD  = 3'd5,
        CMD_ZQ  = 3'd6,
        CMD_NOP = 3'd7
    } mem_cmd_e;

    typedef enum logic [3:0] {
        PH_POWER    = 4'd0,
        PH_CKE_WAIT = 4'd1,
        PH_MR2_DONE = 4'd2,
        PH_MR1_DONE = 4'd3,
        PH_MR0_DONE = 4'd4,
        PH_ZQ_DONE  = 4'd5,
        PH_PRE_DONE = 4'd6,
        PH_REF_DONE = 4'd7,
        PH_RUN      = 4'd8
    } phase_e;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_EARLY = 2'd1,
        ERR_BAD   = 2'd2,
        ERR_POWER = 2'd3
    } err_e;

    typedef struct packed {
        logic [5:0] code;
        logic       powered;
        mem_cmd_e   op;
    } bus_view_t;

    function automatic logic [5:0] pin_code(input logic rst_n, input logic cke,
                                            input logic cs_n, input logic ras_n,
                                            input logic cas_n, input logic we_n);
        return {~rst_n, ~cke, cs_n, ras_n, cas_n, we_n};
    endfunction

    function automatic mem_cmd_e code_to_op(input logic [5:0] code);
        if (code[3])
            return CMD_NOP;
        return mem_cmd_e'(code[2:0]);
    endfunction

endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
    import ddr3_init_mon_pkg::*;
(
    input  logic      mem_reset_n,
    input  logic      mem_cke,
    input  logic      mem_cs_n,
    input  logic      mem_ras_n,
    input  logic      mem_cas_n,
    input  logic      mem_we_n,
    output bus_view_t view
);
    logic [5:0] code;

    always_comb begin
        code         = pin_code(mem_reset_n, mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n);
        view.code    = code;
        view.powered = (code[5:4] == 2'b00);
        view.op      = code_to_op(code);
    end
endmodule

// File: rtl/ddr3_phase_counter.sv
module ddr3_phase_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (inc && count != CNT_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/ddr3_step_rules.sv
module ddr3_step_rules
    import ddr3_init_mon_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int BA_W     = 3,
    parameter int MIN_CKE  = 148,
    parameter int MIN_MRD  = 4,
    parameter int MIN_MOD  = 12,
    parameter int MIN_ZQ   = 513,
    parameter int MIN_RP   = 4
) (
    input  phase_e           phase,
    input  mem_cmd_e         op,
    input  logic [BA_W-1:0]  ba,
    input  logic             a10,
    input  logic [CNT_W-1:0] count,
    output logic             type_ok,
    output logic             gap_ok
);
    logic [CNT_W-1:0] min_gap;

    always_comb begin
        type_ok = 1'b0;
        min_gap = '0;
        unique case (phase)
            PH_CKE_WAIT: begin
                type_ok = (op == CMD_MRS) && (ba == BA_W'(2));
                min_gap = CNT_W'(MIN_CKE);
            end
            PH_MR2_DONE: begin
                type_ok = (op == CMD_MRS) && (ba == BA_W'(1));
                min_gap = CNT_W'(MIN_MRD);
            end
            PH_MR1_DONE: begin
                type_ok = (op == CMD_MRS) && (ba == BA_W'(0));
                min_gap = CNT_W'(MIN_MRD);
            end
            PH_MR0_DONE: begin
                type_ok = (op == CMD_ZQ) && a10;
                min_gap = CNT_W'(MIN_MOD);
            end
            PH_ZQ_DONE: begin
                type_ok = (op == CMD_PRE) && a10;
                min_gap = CNT_W'(MIN_ZQ);
            end
            PH_PRE_DONE: begin
                type_ok = (op == CMD_REF);
                min_gap = CNT_W'(MIN_RP);
            end
            default: ;
        endcase
        gap_ok = (count >= min_gap);
    end
endmodule

// File: rtl/ddr3_init_monitor.sv
module ddr3_init_monitor
    import ddr3_init_mon_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int BA_W     = 3,
    parameter int MIN_CKE  = 148,
    parameter int MIN_MRD  = 4,
    parameter int MIN_MOD  = 12,
    parameter int MIN_ZQ   = 513,
    parameter int MIN_RP   = 4,
    parameter int REF_IDLE = 141
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mem_reset_n,
    input  logic             mem_cke,
    input  logic             mem_cs_n,
    input  logic             mem_ras_n,
    input  logic             mem_cas_n,
    input  logic             mem_we_n,
    input  logic [BA_W-1:0]  mem_ba,
    input  logic             mem_a10,
    output logic             err_pulse,
    output logic [1:0]       err_kind,
    output logic [3:0]       err_phase,
    output logic [3:0]       phase,
    output logic [CNT_W-1:0] phase_count,
    output logic             init_done
);
    localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(REF_IDLE - 1);

    bus_view_t view;
    phase_e    phase_q, phase_d;
    err_e      kind_q, kind_d;
    logic      failed_q, raise, ctr_clr, ctr_inc;
    logic      type_ok, gap_ok;
    logic [3:0] err_phase_q;
    logic      pulse_q;

    ddr3_cmd_decode u_dec (
        .mem_reset_n (mem_reset_n),
        .mem_cke     (mem_cke),
        .mem_cs_n    (mem_cs_n),
        .mem_ras_n   (mem_ras_n),
        .mem_cas_n   (mem_cas_n),
        .mem_we_n    (mem_we_n),
        .view        (view)
    );

    ddr3_step_rules #(
        .CNT_W (CNT_W), .BA_W (BA_W), .MIN_CKE (MIN_CKE), .MIN_MRD (MIN_MRD),
        .MIN_MOD (MIN_MOD), .MIN_ZQ (MIN_ZQ), .MIN_RP (MIN_RP)
    ) u_rules (
        .phase   (phase_q),
        .op      (view.op),
        .ba      (mem_ba),
        .a10     (mem_a10),
        .count   (phase_count),
        .type_ok (type_ok),
        .gap_ok  (gap_ok)
    );

    ddr3_phase_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctr_clr),
        .inc   (ctr_inc),
        .count (phase_count)
    );

    // Step sequencing: power loss outranks command type, type outranks spacing.
    always_comb begin
        phase_d = phase_q;
        kind_d  = ERR_NONE;
        raise   = 1'b0;
        ctr_clr = 1'b0;
        ctr_inc = 1'b0;
        if (!failed_q) begin
            if (phase_q == PH_POWER) begin
                if (view.powered) begin
                    phase_d = PH_CKE_WAIT;
                    ctr_clr = 1'b1;
                end else begin
                    ctr_inc = 1'b1;
                end
            end else if (!view.powered) begin
                raise  = 1'b1;
                kind_d = ERR_POWER;
            end else if (phase_q == PH_RUN) begin
                if (view.op == CMD_MRS) begin
                    raise  = 1'b1;
                    kind_d = ERR_BAD;
                end else begin
                    ctr_inc = 1'b1;
                end
            end else if (phase_q == PH_REF_DONE) begin
                if (view.op != CMD_NOP) begin
                    raise  = 1'b1;
                    kind_d = ERR_BAD;
                end else if (phase_count == REF_LAST) begin
                    phase_d = PH_RUN;
                    ctr_clr = 1'b1;
                end else begin
                    ctr_inc = 1'b1;
                end
            end else if (view.op == CMD_NOP) begin
                ctr_inc = 1'b1;
            end else if (!type_ok) begin
                raise  = 1'b1;
                kind_d = ERR_BAD;
            end else if (!gap_ok) begin
                raise  = 1'b1;
                kind_d = ERR_EARLY;
            end else begin
                phase_d = phase_e'(phase_q + 4'd1);
                ctr_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= PH_POWER;
            failed_q    <= 1'b0;
            kind_q      <= ERR_NONE;
            err_phase_q <= '0;
            pulse_q     <= 1'b0;
        end else begin
            phase_q <= phase_d;
            pulse_q <= raise;
            if (raise) begin
                failed_q    <= 1'b1;
                kind_q      <= kind_d;
                err_phase_q <= phase_q;
            end
        end
    end

    assign err_pulse = pulse_q;
    assign err_kind  = kind_q;
    assign err_phase = err_phase_q;
    assign phase     = phase_q;
    assign init_done = (phase_q == PH_RUN);

endmodule

// File: rtl/ddr3_init_monitor_chk.sv
module ddr3_init_monitor_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             mem_cke,
    input logic             err_pulse,
    input logic [1:0]       err_kind,
    input logic [3:0]       phase,
    input logic [CNT_W-1:0] phase_count,
    input logic             init_done
);
    logic seen;

    always_ff @(posedge clk) begin
        if (rst)
            seen <= 1'b0;
        else if (err_pulse)
            seen <= 1'b1;
    end

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);

    assert_frozen_after_error_R9: assert property (@(posedge clk) disable iff (rst)
        seen |-> ($stable(phase) && $stable(phase_count) && $stable(err_kind)));

    assert_phase_steps_by_one_R3: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> (phase == $past(phase) + 4'd1));

    assert_done_from_ref_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> ($past(phase) == 4'd7));

    assert_run_cke_loss_R6: assert property (@(posedge clk) disable iff (rst)
        (init_done && !mem_cke && !seen && !err_pulse) |=> err_pulse);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
        (phase_count != $past(phase_count)) |->
            ((phase_count == $past(phase_count) + CNT_W'(1)) || (phase_count == '0)));

endmodule

bind ddr3_init_monitor ddr3_init_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_cke     (mem_cke),
    .err_pulse   (err_pulse),
    .err_kind    (err_kind),
    .phase       (phase),
    .phase_count (phase_count),
    .init_done   (init_done)
);

// File: tb/tb_ddr3_init_monitor.sv
module tb_ddr3_init_monitor;

    localparam logic [3:0] C_NOP = 4'b0111, C_DES = 4'b1111, C_MRS = 4'b0000,
                           C_REF = 4'b0001, C_PRE = 4'b0010, C_ACT = 4'b0011,
                           C_RD  = 4'b0101, C_ZQ  = 4'b0110;
    localparam int K_EARLY = 1, K_BAD = 2, K_PWR = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic rn = 1'b0, ck = 1'b0, cs = 1'b1, ras = 1'b1, cas = 1'b1, we = 1'b1;
    logic [2:0] ba = '0;
    logic a10 = 1'b0;

    logic        err_pulse, init_done;
    logic [1:0]  err_kind;
    logic [3:0]  err_phase, phase;
    logic [11:0] phase_count;

    ddr3_init_monitor dut (
        .clk (clk), .rst (rst), .mem_reset_n (rn), .mem_cke (ck),
        .mem_cs_n (cs), .mem_ras_n (ras), .mem_cas_n (cas), .mem_we_n (we),
        .mem_ba (ba), .mem_a10 (a10),
        .err_pulse (err_pulse), .err_kind (err_kind), .err_phase (err_phase),
        .phase (phase), .phase_count (phase_count), .init_done (init_done)
    );

    int checks = 0;
    int errors = 0;

    typedef struct { int kind; int ph; int cnt; string req; } exp_t;
    exp_t q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: pop one expected error per observed pulse
    always @(negedge clk) begin
        if (!rst && err_pulse) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9", "unexpected err_pulse", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(int'(err_kind) == e.kind, e.req, "err_kind", int'(err_kind), e.kind);
                chk(int'(err_phase) == e.ph, e.req, "err_phase", int'(err_phase), e.ph);
                chk(int'(phase_count) == e.cnt, e.req, "latched count", int'(phase_count), e.cnt);
            end
        end
    end

    task automatic expect_err(input int k, input int p, input int c, input string req);
        exp_t e;
        e.kind = k; e.ph = p; e.cnt = c; e.req = req;
        q.push_back(e);
    endtask

    task automatic cyc(input bit r, input bit k, input logic [3:0] c4,
                       input logic [2:0] b, input bit a);
        rn = r; ck = k; {cs, ras, cas, we} = c4; ba = b; a10 = a;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(1'b1, 1'b1, C_NOP, 3'd0, 1'b0);
    endtask

    task automatic drain(input string req);
        idle(2);
        chk(q.size() == 0, req, "expected errors still pending", q.size(), 0);
        q.delete();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) cyc(1'b0, 1'b0, C_NOP, 3'd0, 1'b0);
        rst = 1'b0;
        q.delete();
    endtask

    task automatic power_up();
        repeat (3) cyc(1'b0, 1'b0, C_NOP, 3'd0, 1'b0);
        repeat (3) cyc(1'b1, 1'b0, C_NOP, 3'd0, 1'b0);
        cyc(1'b1, 1'b1, C_NOP, 3'd0, 1'b0);
    endtask

    // Legal bring-up that stops once the given phase has been entered
    task automatic good_init(input int stop);
        power_up();
        if (stop == 1) return;
        idle(100);
        repeat (48) cyc(1'b1, 1'b1, C_DES, 3'd0, 1'b0);
        cyc(1'b1, 1'b1, C_MRS, 3'd2, 1'b0);
        if (stop == 2) return;
        idle(4);  cyc(1'b1, 1'b1, C_MRS, 3'd1, 1'b0);
        if (stop == 3) return;
        idle(4);  cyc(1'b1, 1'b1, C_MRS, 3'd0, 1'b0);
        if (stop == 4) return;
        idle(12); cyc(1'b1, 1'b1, C_ZQ, 3'd0, 1'b1);
        if (stop == 5) return;
        idle(513); cyc(1'b1, 1'b1, C_PRE, 3'd0, 1'b1);
        if (stop == 6) return;
        idle(4);  cyc(1'b1, 1'b1, C_REF, 3'd0, 1'b0);
        if (stop == 7) return;
        idle(141);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2 reset state
        chk(phase == 4'd0, "R2", "phase after reset", phase, 0);
        chk(phase_count == 12'd0, "R2", "count after reset", phase_count, 0);
        chk(init_done == 1'b0, "R2", "init_done after reset", init_done, 0);
        chk(err_pulse == 1'b0 && err_kind == 2'd0, "R2", "error after reset", err_kind, 0);

        // R3 / R10: power phase holds until both reset_n and cke high
        repeat (3) cyc(1'b0, 1'b0, C_NOP, 3'd0, 1'b0);
        repeat (3) cyc(1'b1, 1'b0, C_MRS, 3'd0, 1'b0);
        chk(phase == 4'd0, "R3", "phase while cke low", phase, 0);
        chk(phase_count == 12'd6, "R10", "count in power phase", phase_count, 6);
        cyc(1'b1, 1'b1, C_NOP, 3'd0, 1'b0);
        chk(phase == 4'd1, "R3", "phase after cke rise", phase, 1);
        chk(phase_count == 12'd0, "R10", "count on phase entry", phase_count, 0);

        // R1 / R3 / R5 / R7: full legal bring-up with exact minimum gaps
        do_reset();
        good_init(2);
        chk(phase == 4'd2, "R1", "deselect counted as NOOP, phase", phase, 2);
        idle(4); cyc(1'b1, 1'b1, C_MRS, 3'd1, 1'b0);
        idle(4); cyc(1'b1, 1'b1, C_MRS, 3'd0, 1'b0);
        idle(12); cyc(1'b1, 1'b1, C_ZQ, 3'd0, 1'b1);
        chk(phase == 4'd5, "R5", "phase after calibration", phase, 5);
        idle(513); cyc(1'b1, 1'b1, C_PRE, 3'd0, 1'b1);
        idle(4); cyc(1'b1, 1'b1, C_REF, 3'd0, 1'b0);
        chk(phase == 4'd7, "R3", "phase after refresh", phase, 7);
        idle(140);
        chk(init_done == 1'b0, "R7", "init_done after 140 idles", init_done, 0);
        idle(1);
        chk(init_done == 1'b1, "R7", "init_done after 141 idles", init_done, 1);
        chk(phase == 4'd8, "R7", "operational phase", phase, 8);
        // R8: normal commands pass, MRS is flagged
        cyc(1'b1, 1'b1, C_ACT, 3'd3, 1'b0);
        cyc(1'b1, 1'b1, C_RD, 3'd3, 1'b0);
        idle(2);
        chk(err_kind == 2'd0, "R8", "no error for activate/read", err_kind, 0);
        expect_err(K_BAD, 8, 4, "R8");
        cyc(1'b1, 1'b1, C_MRS, 3'd0, 1'b0);
        drain("R8");

        // R5: first MRS one clock early
        do_reset();
        good_init(1);
        idle(147);
        expect_err(K_EARLY, 1, 147, "R5");
        cyc(1'b1, 1'b1, C_MRS, 3'd2, 1'b0);
        drain("R5");

        // R4: MRS to the wrong mode register
        do_reset();
        good_init(1);
        idle(148);
        expect_err(K_BAD, 1, 148, "R4");
        cyc(1'b1, 1'b1, C_MRS, 3'd1, 1'b0);
        drain("R4");

        // R6 / R9: cke drop in phase 3, then latch hold
        do_reset();
        good_init(3);
        idle(2);
        expect_err(K_PWR, 3, 2, "R6");
        cyc(1'b1, 1'b0, C_NOP, 3'd0, 1'b0);
        idle(10);
        cyc(1'b1, 1'b1, C_MRS, 3'd0, 1'b0);
        cyc(1'b1, 1'b0, C_NOP, 3'd0, 1'b0);
        drain("R9");
        chk(phase == 4'd3, "R9", "phase held", phase, 3);
        chk(phase_count == 12'd2, "R9", "count held", phase_count, 2);
        chk(err_kind == 2'd3, "R9", "kind held", err_kind, 3);
        do_reset();
        chk(err_kind == 2'd0 && phase == 4'd0, "R2", "reset clears latch", err_kind, 0);

        // R5: calibration window one short
        do_reset();
        good_init(5);
        idle(512);
        expect_err(K_EARLY, 5, 512, "R5");
        cyc(1'b1, 1'b1, C_PRE, 3'd0, 1'b1);
        drain("R5");

        // R4: precharge without all-bank scope
        do_reset();
        good_init(5);
        idle(513);
        expect_err(K_BAD, 5, 513, "R4");
        cyc(1'b1, 1'b1, C_PRE, 3'd0, 1'b0);
        drain("R4");

        // R7: command inside the post-refresh idle window
        do_reset();
        good_init(7);
        idle(5);
        expect_err(K_BAD, 7, 5, "R7");
        cyc(1'b1, 1'b1, C_ACT, 3'd0, 1'b0);
        drain("R7");

        // R10 / R6: saturation in run phase, then cke loss
        do_reset();
        good_init(8);
        idle(5000);
        chk(phase_count == 12'd4095, "R10", "saturated count", phase_count, 4095);
        expect_err(K_PWR, 8, 4095, "R6");
        cyc(1'b1, 1'b0, C_NOP, 3'd0, 1'b0);
        drain("R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule